// File: doc/BRIEF.md
# Two-Bank Interrupt Mask Controller

This block gathers up to 64 level-sensitive peripheral interrupt lines into two banks of 32. Each bank has an enable mask and a routing register. The routing register sends every enabled source either to the normal interrupt line or to the fast interrupt line. The block reports what is pending for each of the two lines, drives both lines as registered active-high outputs, and produces an idle-wake signal. A control bit selects whether any raw source may wake the core from idle, or only enabled ones may.

Software reaches the block through a single-cycle read/write port. A register address is made of a 3-bit register kind above a bank-select bit. The kinds are: 0 mask, 1 routing, 2 mask bit-set, 3 mask bit-clear, 4 pending on the normal line, 5 pending on the fast line, 6 control. A low range of source indices, below the parameter SKIP (8 by default), is reserved and never used.

Top module: `intmask_top`

## Requirements
- R1: After reset, every mask bit, every routing bit and the idle-control bit read 0, and the normal and fast interrupt outputs are low.
- R2: A mask bit of 1 enables its source and 0 blocks it. A direct mask write (kind 0) replaces the whole bank. A read returns data on bus_rdata one cycle after the request.
- R3: A write to kind 2 ORs the write data into the bank's mask. A write to kind 3 clears the mask bits that are 1 in the data. Every other mask bit keeps its value.
- R4: An enabled, active source with routing bit 0 drives the normal line. The same source with routing bit 1 drives the fast line instead.
- R5: Reads of kind 4 and kind 5 return, per bank, the raw input ANDed with the mask and with the inverted or the true routing bit.
- R6: irq_o and fiq_o are the OR of the matching pending bits across both banks, registered. A change of a source, mask or routing bit shows on them one clock later.
- R7: Sources 32 to 63 use the second bank (bank-select bit 1), whose mask and routing registers have the same layout and behaviour as the first bank.
- R8: Source indices below SKIP are reserved. Their mask and routing bits ignore writes and read 0, and they never raise an interrupt or a wake.
- R9: With the idle-control bit (kind 6, bit 0) at 1, wake_o is raised only by a source that is both active and enabled.
- R10: With the idle-control bit at 0, wake_o is raised by any active non-reserved source, whether masked or not. Like irq_o, wake_o is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt sources |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3+BSEL_W | Register kind (upper 3 bits) and bank select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| wake_o | output | 1 | Idle-wake request |

## Verification
A software write to a mask or routing register can land in the same cycle in which its source goes active. The bench drives both on one falling edge.

The scoreboard predicts outputs from the register values held before that write. In the collision cycle it expects the line to follow the old mask or routing, and only one cycle later the new one. A mask clear against a rising source must therefore leave irq_o high for exactly one more cycle. A routing flip must move the request from irq_o to fiq_o with no cycle in which both lines are high.

// File: rtl/intmask_pkg.sv
package intmask_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        K_MASK  = 3'd0,
        K_STEER = 3'd1,
        K_MSET  = 3'd2,
        K_MCLR  = 3'd3,
        K_PIRQ  = 3'd4,
        K_PFIQ  = 3'd5,
        K_CTRL  = 3'd6,
        K_NONE  = 3'd7
    } reg_kind_e;

    typedef struct packed {
        logic irq;
        logic fiq;
        logic wake;
    } line_t;

    // bits of one bank whose global index lies at or above the skip offset
    function automatic logic [WORD_W-1:0] usable_bits(int bank, int skip);
        logic [WORD_W-1:0] r;
        r = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (bank * WORD_W + i >= skip) r[i] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/intmask_regs.sv
module intmask_regs
    import intmask_pkg::*;
#(
    parameter int NBANK  = 2,
    parameter int SKIP   = 8,
    parameter int BSEL_W = 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  reg_kind_e                     kind,
    input  logic [BSEL_W-1:0]             bank,
    input  logic [WORD_W-1:0]             wdata,
    output logic [NBANK-1:0][WORD_W-1:0]  mask_q,
    output logic [NBANK-1:0][WORD_W-1:0]  steer_q,
    output logic                          idle_q
);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic [WORD_W-1:0] USE = usable_bits(b, SKIP);

        logic              hit;
        logic [WORD_W-1:0] m_r, s_r, m_d, s_d;

        assign hit = wr_en && (int'(bank) == b);

        always_comb begin
            m_d = m_r;
            s_d = s_r;
            if (hit) begin
                case (kind)
                    K_MASK:  m_d = wdata & USE;
                    K_MSET:  m_d = m_r | (wdata & USE);
                    K_MCLR:  m_d = m_r & ~wdata;
                    K_STEER: s_d = wdata & USE;
                    default: ;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                m_r <= '0;
                s_r <= '0;
            end else begin
                m_r <= m_d;
                s_r <= s_d;
            end
        end

        assign mask_q[b]  = m_r;
        assign steer_q[b] = s_r;
    end

    always_ff @(posedge clk) begin
        if (rst)                         idle_q <= 1'b0;
        else if (wr_en && kind == K_CTRL) idle_q <= wdata[0];
    end

endmodule

// File: rtl/intmask_route.sv
module intmask_route
    import intmask_pkg::*;
#(
    parameter int NBANK = 2,
    parameter int SKIP  = 8
) (
    input  logic [NBANK-1:0][WORD_W-1:0]  src,
    input  logic [NBANK-1:0][WORD_W-1:0]  mask,
    input  logic [NBANK-1:0][WORD_W-1:0]  steer,
    output logic [NBANK-1:0][WORD_W-1:0]  pend_irq,
    output logic [NBANK-1:0][WORD_W-1:0]  pend_fiq,
    output logic                          any_irq,
    output logic                          any_fiq,
    output logic                          any_enabled,
    output logic                          any_raw
);

    logic [NBANK-1:0] irq_hit, fiq_hit, en_hit, raw_hit;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic [WORD_W-1:0] USE = usable_bits(b, SKIP);
        logic [WORD_W-1:0] live;

        assign live        = src[b] & mask[b];
        assign pend_irq[b] = live & ~steer[b];
        assign pend_fiq[b] = live & steer[b];
        assign irq_hit[b]  = |pend_irq[b];
        assign fiq_hit[b]  = |pend_fiq[b];
        assign en_hit[b]   = |live;
        assign raw_hit[b]  = |(src[b] & USE);
    end

    assign any_irq     = |irq_hit;
    assign any_fiq     = |fiq_hit;
    assign any_enabled = |en_hit;
    assign any_raw     = |raw_hit;

endmodule

// File: rtl/intmask_outs.sv
module intmask_outs
    import intmask_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  any_irq,
    input  logic  any_fiq,
    input  logic  any_enabled,
    input  logic  any_raw,
    input  logic  idle_q,
    output line_t line_q
);

    line_t line_d;

    always_comb begin
        line_d.irq  = any_irq;
        line_d.fiq  = any_fiq;
        line_d.wake = idle_q ? any_enabled : any_raw;
    end

    always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= line_d;
    end

endmodule

// File: rtl/intmask_top.sv
module intmask_top
    import intmask_pkg::*;
#(
    parameter  int NUM_SRC = 64,
    parameter  int SKIP    = 8,
    localparam int NBANK   = NUM_SRC / WORD_W,
    localparam int BSEL_W  = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int ADDR_W  = 3 + BSEL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_en,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic               irq_o,
    output logic               fiq_o,
    output logic               wake_o
);

    logic [NBANK-1:0][WORD_W-1:0] src_b, mask_q, steer_q, pend_irq, pend_fiq;
    logic                         idle_q, wr_en;
    logic                         any_irq, any_fiq, any_enabled, any_raw;
    reg_kind_e                    kind;
    logic [BSEL_W-1:0]            bank;
    line_t                        line_q;
    logic [WORD_W-1:0]            rd_d;

    assign src_b = src_i;
    assign kind  = reg_kind_e'(bus_addr[ADDR_W-1 -: 3]);
    assign bank  = bus_addr[BSEL_W-1:0];
    assign wr_en = bus_en && bus_wr;

    intmask_regs #(.NBANK(NBANK), .SKIP(SKIP), .BSEL_W(BSEL_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .kind    (kind),
        .bank    (bank),
        .wdata   (bus_wdata),
        .mask_q  (mask_q),
        .steer_q (steer_q),
        .idle_q  (idle_q)
    );

    intmask_route #(.NBANK(NBANK), .SKIP(SKIP)) u_route (
        .src         (src_b),
        .mask        (mask_q),
        .steer       (steer_q),
        .pend_irq    (pend_irq),
        .pend_fiq    (pend_fiq),
        .any_irq     (any_irq),
        .any_fiq     (any_fiq),
        .any_enabled (any_enabled),
        .any_raw     (any_raw)
    );

    intmask_outs u_outs (
        .clk         (clk),
        .rst         (rst),
        .any_irq     (any_irq),
        .any_fiq     (any_fiq),
        .any_enabled (any_enabled),
        .any_raw     (any_raw),
        .idle_q      (idle_q),
        .line_q      (line_q)
    );

    assign irq_o  = line_q.irq;
    assign fiq_o  = line_q.fiq;
    assign wake_o = line_q.wake;

    always_comb begin
        rd_d = '0;
        case (kind)
            K_MASK, K_MSET, K_MCLR: rd_d = mask_q[bank];
            K_STEER:                rd_d = steer_q[bank];
            K_PIRQ:                 rd_d = pend_irq[bank];
            K_PFIQ:                 rd_d = pend_fiq[bank];
            K_CTRL:                 rd_d = {{(WORD_W-1){1'b0}}, idle_q};
            default:                rd_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                  bus_rdata <= '0;
        else if (bus_en && !bus_wr) bus_rdata <= rd_d;
    end

endmodule

// File: rtl/intmask_chk.sv
module intmask_chk
    import intmask_pkg::*;
#(
    parameter int NBANK  = 2,
    parameter int SKIP   = 8,
    parameter int BSEL_W = 1
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NBANK-1:0][WORD_W-1:0] src_b,
    input logic [NBANK-1:0][WORD_W-1:0] mask_q,
    input logic [NBANK-1:0][WORD_W-1:0] steer_q,
    input logic                         idle_q,
    input logic                         wr_en,
    input reg_kind_e                    kind,
    input logic [BSEL_W-1:0]            bank,
    input logic [WORD_W-1:0]            wdata,
    input logic                         irq_o,
    input logic                         fiq_o,
    input logic                         wake_o
);

    // R1: state is clear on the first cycle after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        $fell(rst) |-> (mask_q == '0 && steer_q == '0 && !idle_q && !irq_o && !fiq_o));

    // R6: normal line follows the previous cycle's routed pending state
    a_r6_irq_follows: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> irq_o == $past(|(src_b & mask_q & ~steer_q)));

    // R6: fast line likewise
    a_r6_fiq_follows: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> fiq_o == $past(|(src_b & mask_q & steer_q)));

    // R9: with idle gating on, nothing enabled means no wake
    a_r9_idle_gate: assert property (@(posedge clk) disable iff (rst)
        (idle_q && (src_b & mask_q) == '0) |=> !wake_o);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic [WORD_W-1:0] USE = usable_bits(b, SKIP);

        // R3: bit-set write leaves other bits alone
        a_r3_set_alias: assert property (@(posedge clk) disable iff (rst)
            (wr_en && kind == K_MSET && int'(bank) == b) |=>
            mask_q[b] == ($past(mask_q[b]) | ($past(wdata) & USE)));

        // R3: bit-clear write leaves other bits alone
        a_r3_clr_alias: assert property (@(posedge clk) disable iff (rst)
            (wr_en && kind == K_MCLR && int'(bank) == b) |=>
            mask_q[b] == ($past(mask_q[b]) & ~$past(wdata)));

        // R8: a direct write never enables a reserved source
        a_r8_reserved: assert property (@(posedge clk) disable iff (rst)
            (wr_en && (kind == K_MASK || kind == K_STEER) && int'(bank) == b) |=>
            ((mask_q[b] | steer_q[b]) & ~USE) == '0);
    end

endmodule

bind intmask_top intmask_chk #(.NBANK(NBANK), .SKIP(SKIP), .BSEL_W(BSEL_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .src_b   (src_b),
    .mask_q  (mask_q),
    .steer_q (steer_q),
    .idle_q  (idle_q),
    .wr_en   (wr_en),
    .kind    (kind),
    .bank    (bank),
    .wdata   (bus_wdata),
    .irq_o   (irq_o),
    .fiq_o   (fiq_o),
    .wake_o  (wake_o)
);

// File: tb/test_intmask_top.sv
module test_intmask_top;
    import intmask_pkg::*;

    localparam int NSRC = 64;
    localparam int SKIP = 8;
    localparam logic [63:0] USE = {64{1'b1}} << SKIP;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src = '0;
    logic        bus_en = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        irq_o, fiq_o, wake_o;

    always #2.5 clk = ~clk;

    intmask_top #(.NUM_SRC(NSRC), .SKIP(SKIP)) i_intmask_top (
        .clk(clk), .rst(rst), .src_i(src), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o)
    );

    typedef struct {
        string       req;
        string       what;
        logic [31:0] exp;
    } item_t;

    item_t       sb[$];
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;
    logic [63:0] m_mask = '0, m_steer = '0, cur = '0;
    logic        m_idle = 1'b0;

    // monitor: compare every queued expectation against the ports
    always @(negedge clk) begin
        item_t       it;
        logic [31:0] act;
        while (sb.size() > 0) begin
            it = sb.pop_front();
            case (it.what)
                "rdata": act = bus_rdata;
                "irq":   act = {31'b0, irq_o};
                "fiq":   act = {31'b0, fiq_o};
                default: act = {31'b0, wake_o};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s %s: actual %h expected %h", it.req, it.what, act, it.exp);
            end
        end
    end

    function automatic logic [31:0] half(logic [63:0] v, logic b);
        return b ? v[63:32] : v[31:0];
    endfunction

    function automatic logic [31:0] model_rd(logic [2:0] k, logic b, logic [63:0] s);
        case (k)
            3'd0, 3'd2, 3'd3: return half(m_mask, b);
            3'd1:             return half(m_steer, b);
            3'd4:             return half(s & m_mask & ~m_steer, b);
            3'd5:             return half(s & m_mask & m_steer, b);
            3'd6:             return {31'b0, m_idle};
            default:          return '0;
        endcase
    endfunction

    task automatic model_wr(logic [2:0] k, logic b, logic [31:0] wd);
        logic [63:0] pos, sel;
        pos = b ? {wd, 32'b0} : {32'b0, wd};
        sel = b ? {32'hFFFF_FFFF, 32'b0} : {32'b0, 32'hFFFF_FFFF};
        case (k)
            3'd0: m_mask  = (m_mask & ~sel) | (pos & USE);
            3'd1: m_steer = (m_steer & ~sel) | (pos & USE);
            3'd2: m_mask  = m_mask | (pos & USE);
            3'd3: m_mask  = m_mask & ~pos;
            3'd6: m_idle  = wd[0];
            default: ;
        endcase
    endtask

    // driver: one bus cycle with the current source pattern
    task automatic cyc(string req, logic en, logic wr, logic [2:0] k, logic b, logic [31:0] wd);
        logic [31:0] erd;
        logic        ei, ef, ew;
        @(negedge clk);
        bus_en = en; bus_wr = wr; bus_addr = {k, b}; bus_wdata = wd; src = cur;
        ei  = |(cur & m_mask & ~m_steer);
        ef  = |(cur & m_mask & m_steer);
        ew  = m_idle ? |(cur & m_mask) : |(cur & USE);
        erd = model_rd(k, b, cur);
        @(posedge clk);
        #1;
        sb.push_back('{req, "irq",  {31'b0, ei}});
        sb.push_back('{req, "fiq",  {31'b0, ef}});
        sb.push_back('{req, "wake", {31'b0, ew}});
        if (en && !wr) sb.push_back('{req, "rdata", erd});
        if (en && wr) model_wr(k, b, wd);
    endtask

    task automatic wr(string req, logic [2:0] k, logic b, logic [31:0] wd);
        cyc(req, 1'b1, 1'b1, k, b, wd);
    endtask
    task automatic rd(string req, logic [2:0] k, logic b);
        cyc(req, 1'b1, 1'b0, k, b, '0);
    endtask
    task automatic idle(string req);
        cyc(req, 1'b0, 1'b0, 3'd0, 1'b0, '0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        rd("R1", 3'd0, 1'b0);
        rd("R1", 3'd0, 1'b1);
        rd("R1", 3'd1, 1'b0);
        rd("R1", 3'd6, 1'b0);

        // R10: raw sources wake while everything is masked
        cur = '1;
        idle("R10");
        idle("R10");

        // R2/R8: full mask write, reserved bits stay 0
        wr("R2", 3'd0, 1'b0, 32'hFFFF_FFFF);
        rd("R8", 3'd0, 1'b0);
        cur = 64'h8;
        idle("R8");
        idle("R8");

        // R6/R5: one enabled source on the normal line
        cur = 64'h400;
        idle("R6");
        idle("R6");
        rd("R5", 3'd4, 1'b0);

        // R4: reroute to the fast line, reserved routing bit ignored
        wr("R4", 3'd1, 1'b0, 32'h0000_0401);
        rd("R8", 3'd1, 1'b0);
        idle("R4");
        rd("R5", 3'd5, 1'b0);

        // R3: clear alias removes only bit 10
        wr("R3", 3'd3, 1'b0, 32'h0000_0400);
        rd("R3", 3'd0, 1'b0);
        idle("R2");
        idle("R2");

        // R7: upper bank
        wr("R7", 3'd2, 1'b1, 32'h8000_0001);
        rd("R3", 3'd0, 1'b1);
        wr("R7", 3'd1, 1'b1, 32'h8000_0000);
        cur = 64'h8000_0001_0000_0000;
        idle("R7");
        idle("R7");
        rd("R7", 3'd4, 1'b1);
        rd("R7", 3'd5, 1'b1);

        // R9: idle gating on
        wr("R9", 3'd6, 1'b0, 32'h1);
        rd("R9", 3'd6, 1'b0);
        cur = 64'h400;
        idle("R9");
        idle("R9");
        cur = 64'h10_0000;
        idle("R9");
        idle("R9");

        // R10: idle gating off again
        wr("R10", 3'd6, 1'b0, 32'h0);
        cur = 64'h400;
        idle("R10");
        idle("R10");

        // R6: mask clear in the same cycle as a rising source
        cur = 64'h1_0000_0000;
        idle("R6");
        wr("R6", 3'd3, 1'b1, 32'h1);
        idle("R6");
        idle("R6");

        // R4: routing flip in the same cycle as an active source
        wr("R4", 3'd2, 1'b1, 32'h1);
        idle("R4");
        wr("R4", 3'd1, 1'b1, 32'h8000_0001);
        idle("R4");
        idle("R4");

        // R3: set alias keeps the other upper-bank bits
        wr("R3", 3'd2, 1'b1, 32'h0000_0100);
        rd("R3", 3'd0, 1'b1);
        idle("R3");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule